// File: doc/BRIEF.md
# Gated Control Register Bank

This block holds the 16-bit configuration and status registers of a network interface controller. A small register bus picks one register by index. It writes that register with a write strobe, and it reads it with a read strobe. The read data is registered. The configuration registers can change only while the controller is stopped or suspended. These are the mode register, the initialization-block address and the two current buffer addresses. A write at any other time is dropped without effect.

The command register carries the run state: stopped, started, suspended, transmitter on and receiver on. Each command bit in a write acts on its own. When a start command is accepted, the transmitter-on and receiver-on flags are loaded from the inverse of the two disable bits in the mode register. The initialization-block address can be reached at two index pairs that share one storage, so a write through either pair shows at both. That address keeps its value through reset. Three mode bits are decoded into a 2-bit loopback mode for the datapath. The three 24-bit addresses are exported.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset, STOP=1 and STRT, SPND, TXON and RXON are 0. The mode register is 0, `loop_mode_o`=0, both buffer addresses are 0 and `rdata_o`=0.
- R2: `rdata_o` takes the value of the register indexed by `idx_i` one cycle after a cycle with `rd_i`=1. It holds that value in every cycle without `rd_i`.
- R3: Writes to the mode register (index 1) and to the address registers (indices 2 to 9) take effect only while STOP or SPND is 1. At any other time they are ignored.
- R4: A start command is a write to index 0 with bit 1=1 and bit 0=0. When it arrives while STOP=0, it sets STRT=1, TXON to the inverse of mode bit 1 (transmit disable) and RXON to the inverse of mode bit 0 (receive disable).
- R5: A write to index 0 with bit 0=1 sets STOP=1 and clears STRT, TXON and RXON. A start command is ignored while STOP=1, including in the same write that releases STOP. Bit 2=1 with bit 0=0 releases STOP.
- R6: A write to index 0 with bit 3=1 sets SPND. Bit 4=1 clears SPND. Index 0 reads back STOP, STRT, SPND, TXON and RXON at bits 0 to 4, with zeros above.
- R7: The initialization address low half is at index 2 and again at index 4. Its high byte is at index 3 and again at index 5. A write through either index of a pair is read back at both.
- R8: Bit 0 of the initialization address always reads 0. Only bits 7..0 of its high register are kept, and bits 15..8 read 0. `init_addr_o` is {high byte, low half}.
- R9: The receive buffer address (indices 6 low, 7 high) and the transmit buffer address (indices 8 low, 9 high) are 24-bit. Their high registers keep bits 7..0 only and read 0 above.
- R10: The mode register holds receive disable (bit 0), transmit disable (bit 1), loop enable (bit 2), internal loop (bit 3) and encoder bypass (bit 4), and reads 0 above bit 4. `loop_mode_o` is 0 when loop enable=0. It is 1 when loop enable=1 and internal=0. It is 2 for internal loop with bypass=0 and 3 when all three bits are 1.
- R11: Indices 10 to 15 read as 0, and writes to them change no register.
- R12: Reset does not change the initialization address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | 4 | Register index |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| stop_o | output | 1 | Controller stopped |
| txon_o | output | 1 | Transmitter on |
| rxon_o | output | 1 | Receiver on |
| loop_mode_o | output | 2 | Decoded loopback mode |
| init_addr_o | output | 24 | Initialization-block address |
| rx_buf_addr_o | output | 24 | Current receive buffer address |
| tx_buf_addr_o | output | 24 | Current transmit buffer address |

## Verification
Every register, the run flags and the stored addresses change on the clock edge that samples the write strobe. `loop_mode_o` follows the mode register through logic alone, so it is valid in the same cycle as that register. Read data appears one edge after the read strobe. The bench drives the bus on falling edges, holds each strobe for one full cycle and samples outputs at the next falling edge, half a cycle after the edge that updates them. Hold behaviour is checked by leaving the read strobe low for more cycles while the index moves.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;
  localparam int unsigned IDX_CMD         = 0;
  localparam int unsigned IDX_MODE        = 1;
  localparam int unsigned IDX_IADR_LO     = 2;
  localparam int unsigned IDX_IADR_HI     = 3;
  localparam int unsigned IDX_IADR_LO_ALT = 4;
  localparam int unsigned IDX_IADR_HI_ALT = 5;
  localparam int unsigned NUM_ADDR        = 3;  // init, rx buffer, tx buffer
  localparam int unsigned NUM_IDX_USED    = 10;

  // command write bits
  localparam int unsigned CMD_STOP    = 0;
  localparam int unsigned CMD_START   = 1;
  localparam int unsigned CMD_RELEASE = 2;
  localparam int unsigned CMD_SPND    = 3;
  localparam int unsigned CMD_RESUME  = 4;
  localparam int unsigned CMD_W       = 5;

  typedef enum logic [1:0] {
    LB_NONE      = 2'd0,
    LB_EXTERNAL  = 2'd1,
    LB_INT_CODEC = 2'd2,
    LB_INT_RAW   = 2'd3
  } loop_mode_e;

  typedef struct packed {
    logic codec_bypass;  // bit 4
    logic lb_internal;   // bit 3
    logic lb_en;         // bit 2
    logic tx_dis;        // bit 1
    logic rx_dis;        // bit 0
  } mode_t;

  function automatic int unsigned addr_lo_idx(int unsigned k);
    return (k == 0) ? IDX_IADR_LO : 4 + 2 * k;
  endfunction

  function automatic int unsigned addr_lo_alt_idx(int unsigned k);
    return (k == 0) ? IDX_IADR_LO_ALT : addr_lo_idx(k);
  endfunction

  function automatic int unsigned addr_hi_alt_idx(int unsigned k);
    return (k == 0) ? IDX_IADR_HI_ALT : addr_lo_idx(k) + 1;
  endfunction
endpackage

// File: rtl/ctrl_run_ctrl.sv
module ctrl_run_ctrl
  import ctrl_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              tx_dis_i,
  input  logic              rx_dis_i,
  output logic              stop_o,
  output logic              strt_o,
  output logic              spnd_o,
  output logic              txon_o,
  output logic              rxon_o
);
  logic stop_q, strt_q, spnd_q, txon_q, rxon_q;
  logic do_stop, do_start, do_release;

  assign do_stop    = cmd_wr_i & cmd_i[CMD_STOP];
  // start only from a running (unstopped) state, sampled before this write
  assign do_start   = cmd_wr_i & cmd_i[CMD_START] & ~cmd_i[CMD_STOP] & ~stop_q;
  assign do_release = cmd_wr_i & cmd_i[CMD_RELEASE] & ~cmd_i[CMD_STOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      txon_q <= 1'b0;
      rxon_q <= 1'b0;
    end else if (do_stop) begin
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      txon_q <= 1'b0;
      rxon_q <= 1'b0;
    end else begin
      if (do_release) stop_q <= 1'b0;
      if (do_start) begin
        strt_q <= 1'b1;
        txon_q <= ~tx_dis_i;
        rxon_q <= ~rx_dis_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             spnd_q <= 1'b0;
    else if (cmd_wr_i && cmd_i[CMD_SPND])    spnd_q <= 1'b1;
    else if (cmd_wr_i && cmd_i[CMD_RESUME])  spnd_q <= 1'b0;
  end

  assign stop_o = stop_q;
  assign strt_o = strt_q;
  assign spnd_o = spnd_q;
  assign txon_o = txon_q;
  assign rxon_o = rxon_q;

  // R5
  a_r5_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[CMD_STOP]) |=> (stop_o && !strt_o && !txon_o && !rxon_o));
  a_r5_no_start_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !$rose(strt_o));
  // R4
  a_r4_start_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[CMD_START] && !cmd_i[CMD_STOP] && !stop_o)
      |=> (strt_o && txon_o == !$past(tx_dis_i) && rxon_o == !$past(rx_dis_i)));
  // R6
  a_r6_spnd_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[CMD_SPND]) |=> spnd_o);
endmodule

// File: rtl/ctrl_addr_reg.sv
module ctrl_addr_reg #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 24,
  parameter bit          HAS_RESET  = 1'b1,
  parameter bit          FORCE_LSB0 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] rd_lo_o,
  output logic [DATA_W-1:0] rd_hi_o
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] lo_eff;

  if (HAS_RESET) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (wr_lo_i) lo_q <= wdata_i;
        if (wr_hi_i) hi_q <= wdata_i[HI_W-1:0];
      end
    end
  end else begin : g_norst
    logic unused_rst;
    assign unused_rst = rst_ni;
    always_ff @(posedge clk_i) begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign lo_eff  = {lo_q[DATA_W-1:1], (FORCE_LSB0 ? 1'b0 : lo_q[0])};
  assign addr_o  = {hi_q, lo_eff};
  assign rd_lo_o = lo_eff;
  assign rd_hi_o = DATA_W'(hi_q);

  // R8 R9
  a_r9_lo_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (addr_o[DATA_W-1:1] == $past(wdata_i[DATA_W-1:1])));
  a_r9_hi_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (addr_o[ADDR_W-1:DATA_W] == $past(wdata_i[HI_W-1:0])));
endmodule

// File: rtl/ctrl_loop_decode.sv
module ctrl_loop_decode
  import ctrl_reg_pkg::*;
(
  input  mode_t      mode_i,
  output loop_mode_e loop_mode_o
);
  always_comb begin
    if (!mode_i.lb_en)            loop_mode_o = LB_NONE;
    else if (!mode_i.lb_internal) loop_mode_o = LB_EXTERNAL;
    else if (!mode_i.codec_bypass) loop_mode_o = LB_INT_CODEC;
    else                          loop_mode_o = LB_INT_RAW;
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stop_o,
  output logic              txon_o,
  output logic              rxon_o,
  output logic [1:0]        loop_mode_o,
  output logic [ADDR_W-1:0] init_addr_o,
  output logic [ADDR_W-1:0] rx_buf_addr_o,
  output logic [ADDR_W-1:0] tx_buf_addr_o
);
  localparam int unsigned MODE_W = $bits(mode_t);

  logic [31:0] idx_w;
  logic        cfg_open, cmd_wr, mode_wr;
  logic        stop, strt, spnd, txon, rxon;
  mode_t       mode_q;
  loop_mode_e  loop_mode;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  logic [NUM_ADDR-1:0]             wr_lo, wr_hi;
  logic [NUM_ADDR-1:0][ADDR_W-1:0] addr;
  logic [NUM_ADDR-1:0][DATA_W-1:0] rd_lo, rd_hi;

  assign idx_w    = 32'(idx_i);
  assign cfg_open = stop | spnd;
  assign cmd_wr   = wr_i && idx_w == IDX_CMD;
  assign mode_wr  = wr_i && cfg_open && idx_w == IDX_MODE;

  ctrl_run_ctrl u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_wr_i (cmd_wr),
    .cmd_i    (wdata_i[CMD_W-1:0]),
    .tx_dis_i (mode_q.tx_dis),
    .rx_dis_i (mode_q.rx_dis),
    .stop_o   (stop),
    .strt_o   (strt),
    .spnd_o   (spnd),
    .txon_o   (txon),
    .rxon_o   (rxon)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
  end

  ctrl_loop_decode u_loop (
    .mode_i      (mode_q),
    .loop_mode_o (loop_mode)
  );

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
    localparam int unsigned LO    = addr_lo_idx(k);
    localparam int unsigned LO_AL = addr_lo_alt_idx(k);
    localparam int unsigned HI_AL = addr_hi_alt_idx(k);
    assign wr_lo[k] = wr_i && cfg_open && (idx_w == LO || idx_w == LO_AL);
    assign wr_hi[k] = wr_i && cfg_open && (idx_w == LO + 1 || idx_w == HI_AL);
    // the init address survives reset and must stay word aligned
    ctrl_addr_reg #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .HAS_RESET  (k != 0),
      .FORCE_LSB0 (k == 0)
    ) u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (wr_lo[k]),
      .wr_hi_i (wr_hi[k]),
      .wdata_i (wdata_i),
      .addr_o  (addr[k]),
      .rd_lo_o (rd_lo[k]),
      .rd_hi_o (rd_hi[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (idx_w == IDX_CMD)  rd_mux = DATA_W'({rxon, txon, spnd, strt, stop});
    if (idx_w == IDX_MODE) rd_mux = DATA_W'(mode_q);
    for (int unsigned k = 0; k < NUM_ADDR; k++) begin
      if (idx_w == addr_lo_idx(k) || idx_w == addr_lo_alt_idx(k)) rd_mux = rd_lo[k];
      if (idx_w == addr_lo_idx(k) + 1 || idx_w == addr_hi_alt_idx(k)) rd_mux = rd_hi[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o       = rdata_q;
  assign stop_o        = stop;
  assign txon_o        = txon;
  assign rxon_o        = rxon;
  assign loop_mode_o   = loop_mode;
  assign init_addr_o   = addr[0];
  assign rx_buf_addr_o = addr[1];
  assign tx_buf_addr_o = addr[2];

  // R3
  a_r3_mode_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !stop && !spnd) |=> $stable(mode_q));
  a_r3_rxaddr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop && !spnd) |=> $stable(rx_buf_addr_o));
  // R2
  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R11
  a_r11_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_w >= NUM_IDX_USED) |=> rdata_o == '0);
  // R10
  a_r10_no_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.lb_en |-> loop_mode_o == 2'd0);
endmodule

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/1ps
module ctrl_reg_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  idx_i = '0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic        stop_o, txon_o, rxon_o;
  logic [1:0]  loop_mode_o;
  logic [23:0] init_addr_o, rx_buf_addr_o, tx_buf_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ctrl_reg_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .stop_o(stop_o),
    .txon_o(txon_o), .rxon_o(rxon_o), .loop_mode_o(loop_mode_o),
    .init_addr_o(init_addr_o), .rx_buf_addr_o(rx_buf_addr_o),
    .tx_buf_addr_o(tx_buf_addr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    idx_i = idx[3:0]; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] d);
    idx_i = idx[3:0]; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [1:0] exp_loop(input logic [4:0] m);
    if (!m[2]) return 2'd0;
    if (!m[3]) return 2'd1;
    if (!m[4]) return 2'd2;
    return 2'd3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [23:0] iadr_keep;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 stop", stop_o, 1);
    chk("R1 txon", txon_o, 0);
    chk("R1 rxon", rxon_o, 0);
    chk("R1 loop", loop_mode_o, 0);
    chk("R1 rxaddr", rx_buf_addr_o, 0);
    chk("R1 txaddr", tx_buf_addr_o, 0);
    chk("R1 rdata", rdata_o, 0);
    rd(0, d); chk("R1 cmd", d, 16'h0001);
    rd(1, d); chk("R1 mode", d, 16'h0000);

    // R10 sweep of all mode values
    for (int m = 0; m < 32; m++) begin
      wr(1, 16'hA5E0 | 16'(m));
      rd(1, d); chk("R10 mode readback", d, 32'(m));
      chk("R10 loop decode", loop_mode_o, exp_loop(m[4:0]));
    end

    // R7 R8 alias and masking
    wr(2, 16'h1235);
    rd(4, d); chk("R7 lo alias", d, 16'h1234);
    rd(2, d); chk("R8 lo bit0", d, 16'h1234);
    wr(5, 16'hFF9C);
    rd(3, d); chk("R7 hi alias", d, 16'h009C);
    chk("R8 init addr", init_addr_o, 24'h9C1234);
    wr(3, 16'h0077);
    wr(4, 16'hABCE);
    rd(5, d); chk("R7 hi alias b", d, 16'h0077);
    rd(2, d); chk("R7 lo alias b", d, 16'hABCE);
    chk("R8 init addr b", init_addr_o, 24'h77ABCE);

    // R9 buffer addresses
    wr(6, 16'hBEEF); wr(7, 16'hCC42);
    chk("R9 rx addr", rx_buf_addr_o, 24'h42BEEF);
    rd(7, d); chk("R9 rx hi", d, 16'h0042);
    wr(8, 16'h0003); wr(9, 16'h7F11);
    chk("R9 tx addr", tx_buf_addr_o, 24'h110003);
    rd(8, d); chk("R9 tx lo", d, 16'h0003);
    rd(9, d); chk("R9 tx hi", d, 16'h0011);

    // R4 R5 start under every disable combination, then stop
    for (int dt = 0; dt < 4; dt++) begin
      wr(1, 16'(dt));
      wr(0, 16'h0004);
      chk("R5 release", stop_o, 0);
      wr(0, 16'h0002);
      chk("R4 txon", txon_o, !dt[1]);
      chk("R4 rxon", rxon_o, !dt[0]);
      rd(0, d);
      chk("R4 cmd read", d, {11'd0, !dt[0], !dt[1], 1'b0, 1'b1, 1'b0});
      wr(0, 16'h0001);
      chk("R5 stop", {stop_o, txon_o, rxon_o}, 3'b100);
      rd(0, d); chk("R5 strt clr", d, 16'h0001);
    end

    // R3 gating while running
    wr(1, 16'h0000);
    wr(0, 16'h0004); wr(0, 16'h0002);
    wr(1, 16'h001F);
    rd(1, d); chk("R3 mode gated", d, 16'h0000);
    chk("R3 loop gated", loop_mode_o, 0);
    wr(6, 16'h0000);
    rd(6, d); chk("R3 rx gated", d, 16'hBEEF);
    wr(4, 16'h0000);
    rd(2, d); chk("R3 iadr gated", d, 16'hABCE);
    // R6 suspend opens writes
    wr(0, 16'h0008);
    rd(0, d); chk("R6 spnd set", d, 16'h001E);
    wr(1, 16'h000C);
    rd(1, d); chk("R3 mode in spnd", d, 16'h000C);
    chk("R10 loop int", loop_mode_o, 2);
    wr(0, 16'h0010);
    rd(0, d); chk("R6 spnd clr", d, 16'h001A);
    wr(1, 16'h0000);
    rd(1, d); chk("R3 mode gated again", d, 16'h000C);

    // R5 start ignored while stopped
    wr(0, 16'h0001);
    wr(0, 16'h0002);
    rd(0, d); chk("R5 start while stopped", d, 16'h0001);
    wr(0, 16'h0006);
    rd(0, d); chk("R5 release+start", d, 16'h0000);
    wr(0, 16'h0002);
    rd(0, d); chk("R4 start after release", d, 16'h001A);

    // R11 unused indices
    wr(0, 16'h0001);
    for (int i = 10; i < 16; i++) begin
      wr(i, 16'hFFFF);
      rd(i, d); chk("R11 read zero", d, 0);
    end
    rd(1, d); chk("R11 mode intact", d, 16'h000C);
    rd(6, d); chk("R11 rx intact", d, 16'hBEEF);
    rd(0, d); chk("R11 cmd intact", d, 16'h0001);

    // R2 read timing and hold
    rd(6, d); chk("R2 read", d, 16'hBEEF);
    idx_i = 4'd1;
    @(negedge clk_i); chk("R2 hold", rdata_o, 16'hBEEF);
    idx_i = 4'd9;
    @(negedge clk_i); chk("R2 hold b", rdata_o, 16'hBEEF);

    // R12 init address through reset
    iadr_keep = init_addr_o;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 init addr", init_addr_o, iadr_keep);
    rd(2, d); chk("R12 lo read", d, 16'hABCE);
    rd(0, d); chk("R1 cmd after reset", d, 16'h0001);
    rd(1, d); chk("R1 mode after reset", d, 0);
    chk("R1 rx after reset", rx_buf_addr_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule